// File: doc/BRIEF.md
# DMA Channel Cycle Controller

This block runs the transfer cycle of a single DMA channel in basic mode. A packed 32-bit channel control word is loaded over a valid/ready stream. The block decodes four fields from it: the cycle type, the transfer size, the burst exponent and the remaining-transfer count. Each request from the peripheral or from software starts one burst of transfers. A transfer is one read beat on the memory port followed by one write beat that carries the data just read. Addresses are not incremented.

After every burst the updated control word is sent out on a writeback stream, with its count field lowered to match the transfers still to be done. This writeback is the arbitration point. If transfers remain and a higher-priority channel is contending, the block yields the bus until that contention clears. Otherwise it waits for the next request. When the last transfer is done, the written-back word carries an invalid cycle type and a zero count, and a one-cycle done interrupt follows. Any later request is refused with a one-cycle error pulse.

All three data interfaces use valid/ready. A valid, once raised, stays high with its payload unchanged until ready is seen at a clock edge. The memory port and the writeback port are never valid in the same cycle. The request, contention, yield, interrupt and error pins are plain levels.

Top module: `dma_cycle_ctrl`

## Requirements
- R1: After reset, `cfg_ready` is 1 and `mem_valid`, `wb_valid`, `chan_yield`, `done_irq` and `req_err` are all 0.
- R2: The control word layout is fixed as follows. Bits [2:0] hold the cycle type, and only 001 (basic) is serviced. Bits [13:4] hold the transfer count minus one. Bits [17:14] hold the burst exponent. Bits [25:24] hold the transfer size, which is driven on `mem_size` during every beat.
- R3: Each transfer is a read beat (`mem_we`=0) followed by a write beat (`mem_we`=1) whose `mem_wdata` equals the `mem_rdata` accepted on the read. `mem_valid` and its payload hold until `mem_ready`.
- R4: One request with a basic cycle type performs min(2^E, remaining) transfers, where E is the burst exponent. Exponents above 10 behave as 10, which gives 1024 transfers.
- R5: After a burst that leaves transfers to do, `wb_valid` presents the stored word with bits [13:4] set to remaining−1 and all other bits unchanged. This word is held until `wb_ready` is seen.
- R6: After the final transfer, the written-back word has bits [2:0]=000 and bits [13:4]=0. `done_irq` is high for exactly the one cycle after that writeback is accepted.
- R7: If `hi_prio` is high when a non-final writeback is accepted, `chan_yield` rises in the next cycle. It stays high, and requests are ignored, until the cycle after `hi_prio` is seen low.
- R8: A request seen while idle with a cycle type other than basic starts no beat. `req_err` is high in the next cycle and low again once the request is removed.
- R9: `cfg_ready` is high only while idle. A control word offered together with a request in the same idle cycle is loaded, and the request is dropped without error.
- R10: `dreq` has no effect while a burst or writeback is in progress. The number of transfers in a burst depends only on the exponent and the remaining count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Control word offered |
| cfg_ready | output | 1 | Control word can be accepted (idle) |
| cfg_word | input | 32 | Packed channel control word |
| dreq | input | 1 | Transfer request from peripheral or software |
| hi_prio | input | 1 | A higher-priority channel is contending |
| mem_valid | output | 1 | Memory beat valid |
| mem_ready | input | 1 | Memory beat accepted |
| mem_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_size | output | 2 | Transfer size code from the control word |
| mem_wdata | output | 32 | Write beat data |
| mem_rdata | input | 32 | Read beat data, sampled with mem_ready |
| wb_valid | output | 1 | Updated control word offered for writeback |
| wb_ready | input | 1 | Writeback accepted |
| wb_data | output | 32 | Updated control word |
| chan_yield | output | 1 | Channel is yielding to a higher-priority requester |
| done_irq | output | 1 | One-cycle pulse when the cycle completes |
| req_err | output | 1 | Request refused because the cycle type is not basic |

## Verification
The assertions assume three things about the environment. The reserved bits of a loaded word are zero. A loaded word's cycle type is either basic or one of the refused codes. `mem_rdata` is valid whenever `mem_ready` accepts a read beat. The stimulus builds every control word from separate field values with the reserved bits forced to zero. It raises `mem_ready` and `wb_ready` only at random falling-edge instants, while the matching valid is up, and sets `mem_rdata` in the same step. Requests and contention are pulsed only at chosen points, so that the idle, burst and yield cases are each reached on purpose.

// File: rtl/dma_cc_pkg.sv
package dma_cc_pkg;
  localparam int WORD_W   = 32;
  localparam int TYPE_LSB = 0;
  localparam int TYPE_W   = 3;
  localparam int CNT_LSB  = 4;
  localparam int CNT_W    = 10;
  localparam int EXP_LSB  = 14;
  localparam int EXP_W    = 4;
  localparam int SIZE_LSB = 24;
  localparam int SIZE_W   = 2;

  typedef enum logic [TYPE_W-1:0] {
    CY_STOP  = 3'b000,
    CY_BASIC = 3'b001
  } cycle_e;

  typedef enum logic [2:0] {
    S_IDLE, S_RD, S_WR, S_WB, S_YIELD
  } state_e;
endpackage

// File: rtl/dma_cc_decode.sv
module dma_cc_decode
  import dma_cc_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int CW = CNT_W,
  parameter int EW = EXP_W
) (
  input  logic [W-1:0]      word,
  output logic              is_basic,
  output logic [SIZE_W-1:0] size,
  output logic [CW-1:0]     count,
  output logic [CW-1:0]     burst_last
);
  logic [EW-1:0] exp_raw;
  logic [EW-1:0] exp_eff;
  logic [CW:0]   one_hot;
  logic [CW:0]   span;

  always_comb begin
    is_basic = (word[TYPE_LSB +: TYPE_W] == CY_BASIC);
    size     = word[SIZE_LSB +: SIZE_W];
    count    = word[CNT_LSB +: CW];
    exp_raw  = word[EXP_LSB +: EW];
    exp_eff  = (int'(exp_raw) > CW) ? EW'(CW) : exp_raw;
    one_hot  = '0;
    one_hot[exp_eff] = 1'b1;
    span       = one_hot - 1'b1;
    burst_last = span[CW-1:0];
  end
endmodule

// File: rtl/dma_cc_beat.sv
module dma_cc_beat #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  input  logic [CW-1:0] last,
  output logic          at_end
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt_q <= '0;
    else if (inc)      cnt_q <= cnt_q + 1'b1;
  end

  assign at_end = (cnt_q == last);
endmodule

// File: rtl/dma_cycle_ctrl.sv
module dma_cycle_ctrl
  import dma_cc_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  output logic              cfg_ready,
  input  logic [W-1:0]      cfg_word,
  input  logic              dreq,
  input  logic              hi_prio,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [SIZE_W-1:0] mem_size,
  output logic [W-1:0]      mem_wdata,
  input  logic [W-1:0]      mem_rdata,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [W-1:0]      wb_data,
  output logic              chan_yield,
  output logic              done_irq,
  output logic              req_err
);
  state_e         st_q;
  logic [W-1:0]   word_q;
  logic [W-1:0]   data_q;
  logic           fin_q;
  logic           is_basic;
  logic [CNT_W-1:0] count, burst_last;
  logic           at_end;
  logic           start, beat_inc, wr_done;

  dma_cc_decode #(.W(W), .CW(CNT_W), .EW(EXP_W)) u_dec (
    .word(word_q), .is_basic(is_basic), .size(mem_size),
    .count(count), .burst_last(burst_last)
  );

  assign start    = (st_q == S_IDLE) && !cfg_valid && dreq && is_basic;
  assign wr_done  = (st_q == S_WR) && mem_ready;
  assign beat_inc = wr_done && (count != '0) && !at_end;

  dma_cc_beat #(.CW(CNT_W)) u_beat (
    .clk(clk), .rst_n(rst_n), .clr(start), .inc(beat_inc),
    .last(burst_last), .at_end(at_end)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      word_q   <= '0;
      data_q   <= '0;
      fin_q    <= 1'b0;
      done_irq <= 1'b0;
      req_err  <= 1'b0;
    end else begin
      done_irq <= 1'b0;
      req_err  <= (st_q == S_IDLE) && !cfg_valid && dreq && !is_basic;
      unique case (st_q)
        S_IDLE: begin
          if (cfg_valid) word_q <= cfg_word;
          else if (start) begin
            fin_q <= 1'b0;
            st_q  <= S_RD;
          end
        end
        S_RD: if (mem_ready) begin
          data_q <= mem_rdata;
          st_q   <= S_WR;
        end
        S_WR: if (mem_ready) begin
          if (count == '0) begin
            word_q[CNT_LSB +: CNT_W]   <= '0;
            word_q[TYPE_LSB +: TYPE_W] <= CY_STOP;
            fin_q <= 1'b1;
            st_q  <= S_WB;
          end else begin
            word_q[CNT_LSB +: CNT_W] <= count - 1'b1;
            st_q <= at_end ? S_WB : S_RD;
          end
        end
        S_WB: if (wb_ready) begin
          done_irq <= fin_q;
          st_q     <= (!fin_q && hi_prio) ? S_YIELD : S_IDLE;
        end
        S_YIELD: if (!hi_prio) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign cfg_ready  = (st_q == S_IDLE);
  assign mem_valid  = (st_q == S_RD) || (st_q == S_WR);
  assign mem_we     = (st_q == S_WR);
  assign mem_wdata  = data_q;
  assign wb_valid   = (st_q == S_WB);
  assign wb_data    = word_q;
  assign chan_yield = (st_q == S_YIELD);
endmodule

// File: rtl/dma_cycle_ctrl_chk.sv
module dma_cycle_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_ready,
  input logic        mem_valid,
  input logic        mem_ready,
  input logic        mem_we,
  input logic [31:0] mem_wdata,
  input logic        wb_valid,
  input logic        wb_ready,
  input logic [31:0] wb_data,
  input logic        chan_yield,
  input logic        done_irq,
  input logic        req_err
);
  p_mem_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_we) && $stable(mem_wdata));

  p_wb_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_data));

  p_irq_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);

  p_irq_after_wb_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> $past(wb_valid && wb_ready) && wb_data[2:0] == 3'b000);

  p_err_no_beat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> !mem_valid && !wb_valid);

  p_ports_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({cfg_ready, mem_valid, wb_valid, chan_yield}) == 1);

  p_wb_type_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> wb_data[2:0] == 3'b000 || wb_data[2:0] == 3'b001);

  p_read_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_valid) |-> !mem_we);
endmodule

bind dma_cycle_ctrl dma_cycle_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_ready(cfg_ready),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
  .mem_wdata(mem_wdata), .wb_valid(wb_valid), .wb_ready(wb_ready),
  .wb_data(wb_data), .chan_yield(chan_yield), .done_irq(done_irq),
  .req_err(req_err)
);

// File: tb/dma_cycle_ctrl_tb.sv
module dma_cycle_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_valid = 1'b0, dreq = 1'b0, hi_prio = 1'b0;
  logic        mem_ready = 1'b0, wb_ready = 1'b0;
  logic [31:0] cfg_word = '0, mem_rdata = '0;
  logic        cfg_ready, mem_valid, mem_we, wb_valid, chan_yield, done_irq, req_err;
  logic [1:0]  mem_size;
  logic [31:0] mem_wdata, wb_data;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  dma_cycle_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_word(cfg_word), .dreq(dreq), .hi_prio(hi_prio),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_data(wb_data),
    .chan_yield(chan_yield), .done_irq(done_irq), .req_err(req_err)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_word(logic [2:0] ty, logic [9:0] n,
                                          logic [3:0] e, logic [1:0] sz);
    return {6'b0, sz, 6'b0, e, n, 1'b0, ty};
  endfunction

  function automatic int burst_of(logic [3:0] e, int rem);
    int b = 1 << ((e > 4'd10) ? 10 : int'(e));
    return (b < rem) ? b : rem;
  endfunction

  function automatic logic [31:0] exp_wb(logic [31:0] w, int rem_after);
    logic [31:0] r = w;
    if (rem_after == 0) begin r[13:4] = '0; r[2:0] = 3'b000; end
    else r[13:4] = 10'(rem_after - 1);
    return r;
  endfunction

  task automatic load(logic [31:0] w);
    @(negedge clk);
    check("R9 cfg_ready idle", 32'(cfg_ready), 32'd1);
    cfg_valid = 1'b1; cfg_word = w;
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  // one request, one burst, one writeback; returns remaining afterwards
  task automatic burst(logic [31:0] w, ref logic [31:0] cur, ref int rem, input bit prio);
    int exp_beats = burst_of(w[17:14], rem);
    int beats = 0;
    logic [31:0] rd = '0;
    bit last;
    hi_prio = prio;
    dreq = 1'b1;
    @(negedge clk);
    dreq = 1'b0;
    while (!wb_valid) begin
      mem_ready = 1'b0;
      if (mem_valid) begin
        check("R9 cfg_ready busy", 32'(cfg_ready), 32'd0);
        check("R2 mem_size", 32'(mem_size), 32'(w[25:24]));
        dreq = ($urandom % 4 == 0);
        if ($urandom % 3 != 0) begin
          mem_ready = 1'b1;
          if (!mem_we) begin rd = $urandom; mem_rdata = rd; end
          else begin check("R3 wdata", mem_wdata, rd); beats++; end
        end
      end
      @(negedge clk);
    end
    mem_ready = 1'b0; dreq = 1'b0;
    check("R4/R10 beats per burst", 32'(beats), 32'(exp_beats));
    rem -= beats;
    last = (rem == 0);
    while ($urandom % 2) begin
      @(negedge clk);
      check("R5 wb held", 32'(wb_valid), 32'd1);
    end
    check(last ? "R6 final word" : "R5 wb word", wb_data, exp_wb(cur, rem));
    cur = wb_data;
    wb_ready = 1'b1;
    @(negedge clk);
    wb_ready = 1'b0;
    check("R6 irq", 32'(done_irq), 32'(last));
    check("R7 yield", 32'(chan_yield), 32'(prio && !last));
    if (prio && !last) begin
      dreq = 1'b1;
      @(negedge clk);
      dreq = 1'b0;
      check("R7 request ignored", 32'(mem_valid), 32'd0);
      check("R7 still yield", 32'(chan_yield), 32'd1);
      hi_prio = 1'b0;
      @(negedge clk);
      check("R7 yield released", 32'(chan_yield), 32'd0);
    end else begin
      @(negedge clk);
      check("R6 irq one cycle", 32'(done_irq), 32'd0);
    end
    hi_prio = 1'b0;
  endtask

  task automatic run_cycle(logic [31:0] w, bit prio);
    int rem = int'(w[13:4]) + 1;
    logic [31:0] cur = w;
    load(w);
    while (rem > 0) burst(w, cur, rem, prio && ($urandom % 2 == 1));
    dreq = 1'b1;
    @(negedge clk);
    dreq = 1'b0;
    check("R8 refused after finish", 32'(req_err), 32'd1);
    check("R8 no beat", 32'(mem_valid), 32'd0);
    @(negedge clk);
    check("R8 err pulse", 32'(req_err), 32'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R3 watchdog actual=hang expected=progress");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    check("R1 cfg_ready", 32'(cfg_ready), 32'd1);
    check("R1 outputs idle", {27'd0, mem_valid, wb_valid, chan_yield, done_irq, req_err}, 32'd0);
    rst_n = 1'b1;
    // R8: empty word refuses requests; other types too
    dreq = 1'b1; @(negedge clk); dreq = 1'b0;
    check("R8 err from stop type", 32'(req_err), 32'd1);
    load(mk_word(3'b010, 10'd3, 4'd0, 2'd2));
    dreq = 1'b1; @(negedge clk); dreq = 1'b0;
    check("R8 err from autorequest", 32'(req_err), 32'd1);
    check("R8 no beat started", 32'(mem_valid), 32'd0);
    @(negedge clk);
    check("R8 err clears", 32'(req_err), 32'd0);
    // R9: cfg wins over a simultaneous request
    cfg_valid = 1'b1; dreq = 1'b1; cfg_word = mk_word(3'b001, 10'd0, 4'd0, 2'd1);
    @(negedge clk);
    cfg_valid = 1'b0; dreq = 1'b0;
    check("R9 request dropped", 32'(mem_valid), 32'd0);
    check("R9 no error", 32'(req_err), 32'd0);
    run_cycle(mk_word(3'b001, 10'd0, 4'd0, 2'd1), 1'b0);
    // directed: bursts of 4,4,2 ; max count in one burst with capped exponent
    run_cycle(mk_word(3'b001, 10'd9, 4'd2, 2'd0), 1'b1);
    run_cycle(mk_word(3'b001, 10'h3FF, 4'd12, 2'd2), 1'b0);
    run_cycle(mk_word(3'b001, 10'd5, 4'd0, 2'd3), 1'b1);
    for (int i = 0; i < 12; i++)
      run_cycle(mk_word(3'b001, 10'($urandom % 40), 4'($urandom % 5),
                        2'($urandom % 4)), 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule